// File: doc/BRIEF.md
# Byte-Sliced Countdown Timer

This block is a 32-bit down-counter that software controls over a small synchronous register bus with 8-bit data lanes. The start value and the periodic restart value are each written as four single-byte registers, placed one word apart. The most significant byte sits at the lowest offset. A run bit starts and stops the count. When a running count steps down to zero, it raises a sticky event flag. Software clears that flag by writing a one to it. An event-mask bit decides whether the flag drives the level-sensitive interrupt line.

The count can be one-shot or periodic. If the restart value is zero, the counter parks at zero after its event. If the restart value is nonzero, the counter takes that value one cycle after reaching zero and counts down again. Reads are combinational and decode the address of the current cycle. Writes take effect at the next rising clock edge.

Top module: `cdown_timer`

## Requirements
- R1: After synchronous active-high reset, every mapped offset reads 0x00 and `irq` is 0.
- R2: The start value is held in bytes at offsets 0x00, 0x04, 0x08, 0x0C. Its bits 31:24 are at 0x00 and its bits 7:0 are at 0x0C. Each byte reads back what was last written to it.
- R3: The restart value is held in bytes at offsets 0x10, 0x14, 0x18, 0x1C, with the same byte order. Each byte reads back what was last written to it.
- R4: Offset 0x20 bit 0 is the run bit and reads back its stored value. Writing 1 while it is 0 loads the start value S. The event then becomes visible S clock edges after the edge of that write.
- R5: While the run bit is 0, the count is frozen and no event occurs. Writing 1 to the run bit while it is already 1 does not reload the count.
- R6: When a running count steps from 1 to 0, the pending flag (offset 0x3C, bit 0) becomes 1 on that edge.
- R7: With a nonzero restart value R, the counter reloads R one edge after reaching zero. Events then repeat every R+1 edges.
- R8: With a restart value of zero, the counter stays at zero after its event, and no further event occurs.
- R9: Writing a byte with bit 0 set to offset 0x3C clears the pending flag. Writing a byte with bit 0 clear has no effect.
- R10: `irq` equals the pending flag AND the event-mask bit (offset 0x40, bit 0).
- R11: If an event and a clear write land on the same edge, the pending flag ends up as 1.
- R12: Offsets outside the map, including addresses that are not word-aligned, read as 0x00. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (7) | Byte offset of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt: pending AND event mask |

## Verification
The assertions assume one bus access per cycle. They also assume that software does not write the start value in the same cycle as the run bit's rising write. The stimulus respects both: its tasks issue exactly one access per clock, and all byte programming finishes before the run bit is set. Each event is pinned to a cycle by pairing a "still clear" sample one cycle before the computed event edge with a "now set" sample right after it. The same-edge set-versus-clear case is placed deliberately on a computed event edge.

// File: rtl/cdown_timer.sv
module cdown_timer #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam int NBYTES = 4;
  localparam logic [ADDR_W-1:0] OFF_RUN  = ADDR_W'(7'h20);
  localparam logic [ADDR_W-1:0] OFF_PEND = ADDR_W'(7'h3C);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(7'h40);

  logic [7:0]  start_b [NBYTES];
  logic [7:0]  rest_b  [NBYTES];
  logic [31:0] cnt;
  logic        run, pend, mask;

  wire [31:0] start_val = {start_b[0], start_b[1], start_b[2], start_b[3]};
  wire [31:0] rest_val  = {rest_b[0],  rest_b[1],  rest_b[2],  rest_b[3]};

  wire in_bytes = (bus_addr[ADDR_W-1:5] == '0) && (bus_addr[1:0] == 2'b00);
  wire run_wr   = bus_we && (bus_addr == OFF_RUN);
  wire clr_wr   = bus_we && (bus_addr == OFF_PEND) && bus_wdata[0];
  wire mask_wr  = bus_we && (bus_addr == OFF_MASK);
  wire start_go = run_wr && bus_wdata[0] && !run;
  wire hit      = run && (cnt == 32'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBYTES; i++) begin
        start_b[i] <= '0;
        rest_b[i]  <= '0;
      end
      cnt  <= '0;
      run  <= 1'b0;
      pend <= 1'b0;
      mask <= 1'b0;
    end else begin
      for (int i = 0; i < NBYTES; i++) begin
        if (bus_we && in_bytes && !bus_addr[4] && bus_addr[3:2] == 2'(i)) start_b[i] <= bus_wdata;
        if (bus_we && in_bytes &&  bus_addr[4] && bus_addr[3:2] == 2'(i)) rest_b[i]  <= bus_wdata;
      end
      if (run_wr)  run  <= bus_wdata[0];
      if (mask_wr) mask <= bus_wdata[0];
      if (start_go)          cnt <= start_val;
      else if (run) begin
        if (cnt != '0)            cnt <= cnt - 32'd1;
        else if (rest_val != '0)  cnt <= rest_val;
      end
      if (hit)         pend <= 1'b1;
      else if (clr_wr) pend <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (in_bytes)
      bus_rdata = bus_addr[4] ? rest_b[bus_addr[3:2]] : start_b[bus_addr[3:2]];
    else if (bus_addr == OFF_RUN)  bus_rdata = {7'd0, run};
    else if (bus_addr == OFF_PEND) bus_rdata = {7'd0, pend};
    else if (bus_addr == OFF_MASK) bus_rdata = {7'd0, mask};
  end

  assign irq = pend & mask;

  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start_go |=> (cnt == $past(start_val)));
  // R5
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !run_wr) |=> ($stable(cnt) && !$rose(pend)));
  // R6
  event_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend && !$past(rst)) ##1 pend |-> $past(run && cnt == 32'd1));
  // R8
  park_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == '0 && rest_val == '0 && !run_wr) |=> (cnt == '0));
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !hit) |=> !irq);
  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && hit) |=> pend);
  // R12
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_bytes && bus_addr != OFF_RUN && bus_addr != OFF_PEND && bus_addr != OFF_MASK)
      |-> (bus_rdata == 8'h00));
endmodule

// File: tb/tb_cdown_timer.sv
module tb_cdown_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  always #4 clk = ~clk;

  cdown_timer #(.ADDR_W(7)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct {
    logic [7:0] exp_data;
    int         exp_irq;
    string      tag;
  } item_t;

  item_t sb[$];
  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always begin
    @(negedge clk);
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      vectors++;
      if (bus_rdata !== it.exp_data || (it.exp_irq >= 0 && irq !== it.exp_irq[0])) begin
        misses++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%0d",
                 it.tag, bus_rdata, irq, it.exp_data, it.exp_irq);
      end
    end
  end

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 7'h7C;
    end
  endtask

  task automatic chk(input logic [6:0] a, input logic [7:0] d, input int ei, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    it.exp_data = d; it.exp_irq = ei; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic set32(input logic [6:0] base, input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(base + 7'(4 * i), v[31 - 8*i -: 8]);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    chk(7'h00, 8'h00, 0, "R1 start byte");
    chk(7'h1C, 8'h00, 0, "R1 restart byte");
    chk(7'h20, 8'h00, 0, "R1 run");
    chk(7'h3C, 8'h00, 0, "R1 pending");
    chk(7'h40, 8'h00, 0, "R1 mask");
    // R2 / R3 readback and byte order
    set32(7'h00, 32'h12345678);
    set32(7'h10, 32'h9ABCDEF0);
    chk(7'h00, 8'h12, 0, "R2 msb");
    chk(7'h0C, 8'h78, 0, "R2 lsb");
    chk(7'h04, 8'h34, 0, "R2 byte1");
    chk(7'h10, 8'h9A, 0, "R3 msb");
    chk(7'h1C, 8'hF0, 0, "R3 lsb");
    // R12 unmapped writes and reads
    wr(7'h24, 8'hFF); wr(7'h01, 8'hAA); wr(7'h44, 8'h01); wr(7'h3D, 8'h01);
    chk(7'h24, 8'h00, 0, "R12 read 0x24");
    chk(7'h01, 8'h00, 0, "R12 misaligned read");
    chk(7'h00, 8'h12, 0, "R12 start byte untouched");
    chk(7'h40, 8'h00, 0, "R12 mask untouched");
    chk(7'h20, 8'h00, 0, "R12 run untouched");

    // One-shot, start 5, restart 0
    set32(7'h00, 32'd5);
    set32(7'h10, 32'd0);
    wr(7'h40, 8'h01);
    wr(7'h20, 8'h01);
    idle(4);
    chk(7'h3C, 8'h00, 0, "R4 no event before S edges");
    chk(7'h3C, 8'h01, 1, "R6 R10 event at S edges");
    chk(7'h20, 8'h01, 1, "R4 run readback");
    wr(7'h3C, 8'h00);
    chk(7'h3C, 8'h01, 1, "R9 write 0 ignored");
    wr(7'h3C, 8'h01);
    chk(7'h3C, 8'h00, 0, "R9 clear");
    idle(10);
    chk(7'h3C, 8'h00, 0, "R8 parked at zero");
    wr(7'h20, 8'h00);

    // R5 freeze when stopped
    set32(7'h00, 32'd3);
    wr(7'h20, 8'h01);
    wr(7'h20, 8'h00);
    idle(10);
    chk(7'h3C, 8'h00, 0, "R5 frozen no event");
    chk(7'h20, 8'h00, 0, "R5 run cleared");

    // R5 rewrite of run while running does not reload
    set32(7'h00, 32'd6);
    wr(7'h20, 8'h01);
    idle(2);
    wr(7'h20, 8'h01);
    idle(2);
    chk(7'h3C, 8'h00, 0, "R5 before event");
    chk(7'h3C, 8'h01, 1, "R5 no reload on rewrite");
    wr(7'h20, 8'h00);
    wr(7'h3C, 8'h01);

    // Periodic: start 2, restart 3
    set32(7'h00, 32'd2);
    set32(7'h10, 32'd3);
    wr(7'h20, 8'h01);
    idle(1);
    chk(7'h3C, 8'h00, 0, "R7 first event not yet");
    chk(7'h3C, 8'h01, 1, "R7 first event");
    wr(7'h3C, 8'h01);
    chk(7'h3C, 8'h00, 0, "R7 cleared");
    chk(7'h3C, 8'h00, 0, "R7 period not yet");
    chk(7'h3C, 8'h01, 1, "R7 second event R+1 later");
    wr(7'h3C, 8'h01);
    wr(7'h40, 8'h00);
    wr(7'h3C, 8'h01);
    chk(7'h3C, 8'h01, 0, "R11 set beats clear, R10 masked");
    chk(7'h40, 8'h00, 0, "R10 mask readback");
    wr(7'h40, 8'h01);
    chk(7'h3C, 8'h01, 1, "R10 unmasked drives irq");
    wr(7'h20, 8'h00);

    idle(2);
    done = 1'b1;
  end

  initial begin
    #400000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: rdata=%h irq=%b expected run to complete", bus_rdata, irq);
    end
  end

  initial begin
    wait (done || $time > 399000);
    if (!done) #2000;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule